// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits next to a small processor's program counter and its 32-bit status register. Each cycle it looks at the pending event requests: reserved-instruction and address faults, a floating-point fault, an external interrupt, a trap with a 4-bit number, a reset-like request and a system break. It accepts the most urgent one. In the cycle it accepts an event, it drives a redirect pulse together with that event's vector entry address. At the following clock edge it puts the return address into the backup program counter (BPC). It also copies the live status byte into the backup byte that sits just above it in the same register, and clears the interrupt-enable and mode bits in the live byte.

Faults that cancel the instruction save the faulting instruction's own address. Events that let the instruction complete save the address of the next instruction. A return-from-exception request redirects fetch to the BPC and moves the backup byte back into the live byte. A system break never returns. Once it is taken, the block ignores further events. A later return request moves the block into a terminate state, where it asks the system to reset.

A register-access port lets handler software write the BPC or the status register, so that both can be saved and restored on the stack.

The controller has three states:
- RUN: normal operation. Events and returns are accepted here.
- BREAK: entered from RUN when a system break is accepted.
- TERM: entered from BREAK on a return request. This state is left only by reset.

Top module: `evt_ctrl`

## Requirements
- R1: After reset, bpc_q and status_q are 0, term_req is 0 and redirect is 0.
- R2: Fixed acceptance priority applies when several requests are pending in RUN: system break, then reset-like, then address fault, then reserved instruction, then trap, then floating-point, then external interrupt.
- R3: redirect is high in the acceptance cycle, and redirect_pc is VEC_BASE + 4*index. The indices are: reset-like 0, system break 1, reserved instruction 2, address fault 3, floating-point 4, external interrupt 5, and trap n at 16+n.
- R4: Accepting an address or reserved-instruction fault loads bpc_q with pc_cur, with bits 1:0 forced to 0.
- R5: Accepting a trap, floating-point fault, external interrupt or system break loads bpc_q with pc_next, with bits 1:0 forced to 0.
- R6: On accepting any event except reset-like, status bits 15:8 take the old bits 7:0. Bits 7:0 keep their old value except that bit 6 (interrupt enable) and bit 7 (mode) are cleared. Bits 31:16 are unchanged.
- R7: An external interrupt request is ignored while status bit 6 is 0.
- R8: A return request in RUN with no accepted event drives redirect with redirect_pc equal to bpc_q, and loads status bits 7:0 from bits 15:8. A return request loses to an event accepted in the same cycle.
- R9: After a system break is accepted, no request causes a redirect. The next return request sets term_req, and term_req then stays high until reset.
- R10: A reset-like request redirects to index 0, clears status_q to 0 and leaves bpc_q unchanged.
- R11: When acc_we is high, acc_sel=0 writes acc_wdata into bpc_q with bits 1:0 zeroed, and acc_sel=1 writes acc_wdata into status_q. The write is ignored in a cycle where an event or a return request is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_cur | input | XLEN | Address of the instruction at the boundary |
| pc_next | input | XLEN | Address of the following instruction |
| req_sbi | input | 1 | System break request |
| req_rst | input | 1 | Reset-like request |
| req_ae | input | 1 | Address fault request |
| req_rie | input | 1 | Reserved instruction request |
| req_trap | input | 1 | Trap request |
| trap_num | input | TRAP_W | Trap number |
| req_fpe | input | 1 | Floating-point fault request |
| req_ei | input | 1 | External interrupt request |
| rte | input | 1 | Return-from-exception request |
| acc_we | input | 1 | Register-access write strobe |
| acc_sel | input | 1 | Access target: 0 = BPC, 1 = status |
| acc_wdata | input | XLEN | Access write data |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | XLEN | Redirect target address |
| term_req | output | 1 | Terminate/reset request after a break return |
| bpc_q | output | XLEN | Backup program counter |
| status_q | output | XLEN | Status register; bits 15:8 are the backup byte |

## Verification
The hardest situation to reach from the ports is a return after a system break. The stimulus first loads a status value with interrupts enabled through the access port. It then raises a break together with an external interrupt in one cycle, so the priority decision is observed. While in the break state it raises faults, which must not redirect. It then issues the return request, and issues it a second time, to show that term_req stays set. Masked-interrupt behaviour comes from the cleared enable bit left by an earlier entry. The stimulus also applies an event, a return and an access write in the same cycle.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
    localparam int FLD_W    = 8;
    localparam int IE_BIT   = 6;
    localparam int MODE_BIT = 7;
    localparam int NREQ     = 7;

    typedef enum logic [2:0] {
        EV_NONE, EV_SBI, EV_RST, EV_AE, EV_RIE, EV_TRAP, EV_FPE, EV_EI
    } evt_e;

    typedef enum logic [1:0] {
        ST_RUN, ST_BREAK, ST_TERM
    } ctl_state_e;

    function automatic int unsigned evt_index(evt_e e);
        case (e)
            EV_RST:  return 0;
            EV_SBI:  return 1;
            EV_RIE:  return 2;
            EV_AE:   return 3;
            EV_FPE:  return 4;
            EV_EI:   return 5;
            default: return 0;
        endcase
    endfunction

    function automatic logic is_canceled(evt_e e);
        return (e == EV_AE) || (e == EV_RIE);
    endfunction
endpackage

// File: rtl/evt_prio.sv
`timescale 1ns/1ps
module evt_prio
    import evt_pkg::*;
(
    input  logic [NREQ-1:0] req,   // bit 0 is most urgent
    output evt_e            sel
);
    localparam evt_e PRIO [NREQ] = '{EV_SBI, EV_RST, EV_AE, EV_RIE, EV_TRAP, EV_FPE, EV_EI};

    always_comb begin
        sel = EV_NONE;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) sel = PRIO[i];
        end
    end
endmodule

// File: rtl/evt_vecgen.sv
`timescale 1ns/1ps
module evt_vecgen
    import evt_pkg::*;
#(
    parameter int               XLEN      = 32,
    parameter int               TRAP_W    = 4,
    parameter int               TRAP_IDX0 = 16,
    parameter logic [XLEN-1:0]  VEC_BASE  = 'h1000
) (
    input  evt_e              sel,
    input  logic [TRAP_W-1:0] trap_num,
    output logic [XLEN-1:0]   vec_addr
);
    logic [XLEN-1:0] idx;

    always_comb begin
        if (sel == EV_TRAP) idx = XLEN'(TRAP_IDX0) + XLEN'(trap_num);
        else                idx = XLEN'(evt_index(sel));
        vec_addr = VEC_BASE + (idx << 2);
    end
endmodule

// File: rtl/evt_ctrl.sv
`timescale 1ns/1ps
module evt_ctrl
    import evt_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter int               TRAP_W   = 4,
    parameter logic [XLEN-1:0]  VEC_BASE = 'h1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_cur,
    input  logic [XLEN-1:0]   pc_next,
    input  logic              req_sbi,
    input  logic              req_rst,
    input  logic              req_ae,
    input  logic              req_rie,
    input  logic              req_trap,
    input  logic [TRAP_W-1:0] trap_num,
    input  logic              req_fpe,
    input  logic              req_ei,
    input  logic              rte,
    input  logic              acc_we,
    input  logic              acc_sel,
    input  logic [XLEN-1:0]   acc_wdata,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              term_req,
    output logic [XLEN-1:0]   bpc_q,
    output logic [XLEN-1:0]   status_q
);
    localparam logic [XLEN-1:0]  ALIGN_M   = ~XLEN'(3);
    localparam logic [FLD_W-1:0] ENTRY_CLR = FLD_W'((1 << IE_BIT) | (1 << MODE_BIT));

    ctl_state_e      st_q, st_d;
    evt_e            sel;
    logic [NREQ-1:0] req_vec;
    logic [XLEN-1:0] vec_addr;
    logic [XLEN-1:0] save_pc;
    logic            ev_take, ret_take, brk_ret;

    // Request vector, most urgent in bit 0; interrupt gated by enable bit
    assign req_vec = {req_ei & status_q[IE_BIT], req_fpe, req_trap,
                      req_rie, req_ae, req_rst, req_sbi};

    evt_prio u_prio (
        .req (req_vec),
        .sel (sel)
    );

    evt_vecgen #(
        .XLEN     (XLEN),
        .TRAP_W   (TRAP_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .sel      (sel),
        .trap_num (trap_num),
        .vec_addr (vec_addr)
    );

    assign save_pc = is_canceled(sel) ? pc_cur : pc_next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Next state and outputs
    always_comb begin
        st_d        = st_q;
        redirect    = 1'b0;
        redirect_pc = vec_addr;
        ev_take     = 1'b0;
        ret_take    = 1'b0;
        brk_ret     = 1'b0;
        term_req    = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (sel != EV_NONE) begin
                    ev_take  = 1'b1;
                    redirect = 1'b1;
                    if (sel == EV_SBI) st_d = ST_BREAK;
                end else if (rte) begin
                    ret_take    = 1'b1;
                    redirect    = 1'b1;
                    redirect_pc = bpc_q;
                end
            end
            ST_BREAK: begin
                if (rte) begin
                    brk_ret = 1'b1;
                    st_d    = ST_TERM;
                end
            end
            ST_TERM: begin
                term_req = 1'b1;
            end
            default: begin
                st_d = ST_RUN;
            end
        endcase
    end

    // Backup PC and status register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bpc_q    <= '0;
            status_q <= '0;
        end else if (ev_take) begin
            if (sel == EV_RST) begin
                status_q <= '0;
            end else begin
                bpc_q    <= save_pc & ALIGN_M;
                status_q <= {status_q[XLEN-1:2*FLD_W],
                             status_q[FLD_W-1:0],
                             status_q[FLD_W-1:0] & ~ENTRY_CLR};
            end
        end else if (ret_take) begin
            status_q[FLD_W-1:0] <= status_q[2*FLD_W-1:FLD_W];
        end else if (acc_we && !brk_ret) begin
            if (acc_sel) status_q <= acc_wdata;
            else         bpc_q    <= acc_wdata & ALIGN_M;
        end
    end
endmodule

// File: rtl/evt_ctrl_chk.sv
`timescale 1ns/1ps
module evt_ctrl_chk
    import evt_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  VEC_BASE = 'h1000
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_cur,
    input logic [XLEN-1:0] pc_next,
    input logic            req_sbi,
    input logic            req_rst,
    input logic            req_ae,
    input logic            req_rie,
    input logic            req_trap,
    input logic            req_fpe,
    input logic            req_ei,
    input logic            rte,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic            term_req,
    input logic [XLEN-1:0] bpc_q,
    input logic [XLEN-1:0] status_q,
    input evt_e            sel,
    input ctl_state_e      st_q,
    input logic            ev_take,
    input logic            ret_take
);
    localparam logic [XLEN-1:0] AM = ~XLEN'(3);

    AST_SBI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && req_sbi) |-> (redirect && redirect_pc == VEC_BASE + XLEN'(4))); // R2

    AST_CANCEL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take && (sel == EV_AE || sel == EV_RIE)) |=> (bpc_q == ($past(pc_cur) & AM))); // R4

    AST_DONE_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take && (sel == EV_FPE || sel == EV_EI || sel == EV_TRAP)) |=> (bpc_q == ($past(pc_next) & AM))); // R5

    AST_STATUS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take && sel != EV_RST) |=> (status_q[2*FLD_W-1:FLD_W] == $past(status_q[FLD_W-1:0])
                                        && !status_q[IE_BIT] && !status_q[MODE_BIT])); // R6

    AST_EI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && req_ei && !status_q[IE_BIT] && !req_sbi && !req_rst && !req_ae
         && !req_rie && !req_trap && !req_fpe && !rte) |-> !redirect); // R7

    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> (status_q[FLD_W-1:0] == $past(status_q[2*FLD_W-1:FLD_W]))); // R8

    AST_NO_REDIRECT_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |-> !redirect); // R9

    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        term_req |=> term_req); // R9

    AST_RST_KEEPS_BPC: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_take && sel == EV_RST) |=> (status_q == '0 && $stable(bpc_q))); // R10

    AST_BPC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bpc_q[1:0] == 2'b00); // R11
endmodule

bind evt_ctrl evt_ctrl_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .pc_next(pc_next),
    .req_sbi(req_sbi), .req_rst(req_rst), .req_ae(req_ae), .req_rie(req_rie),
    .req_trap(req_trap), .req_fpe(req_fpe), .req_ei(req_ei), .rte(rte),
    .redirect(redirect), .redirect_pc(redirect_pc), .term_req(term_req),
    .bpc_q(bpc_q), .status_q(status_q), .sel(sel), .st_q(st_q),
    .ev_take(ev_take), .ret_take(ret_take)
);

// File: tb/tb_evt_ctrl.sv
`timescale 1ns/1ps
module tb_evt_ctrl;
    localparam logic [31:0] BASE = 32'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_cur = '0, pc_next = '0, acc_wdata = '0;
    logic        req_sbi = 0, req_rst = 0, req_ae = 0, req_rie = 0;
    logic        req_trap = 0, req_fpe = 0, req_ei = 0, rte = 0;
    logic [3:0]  trap_num = '0;
    logic        acc_we = 0, acc_sel = 0;
    logic        redirect, term_req;
    logic [31:0] redirect_pc, bpc_q, status_q;

    always #2 clk = ~clk;

    evt_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pc_cur(pc_cur), .pc_next(pc_next),
        .req_sbi(req_sbi), .req_rst(req_rst), .req_ae(req_ae), .req_rie(req_rie),
        .req_trap(req_trap), .trap_num(trap_num), .req_fpe(req_fpe), .req_ei(req_ei),
        .rte(rte), .acc_we(acc_we), .acc_sel(acc_sel), .acc_wdata(acc_wdata),
        .redirect(redirect), .redirect_pc(redirect_pc), .term_req(term_req),
        .bpc_q(bpc_q), .status_q(status_q)
    );

    typedef struct {
        string       tag;
        bit          redir;
        bit          rpc_ok;
        bit [31:0]   rpc;
        bit          term;
        bit          bpc_ok;
        bit [31:0]   bpc;
        bit [31:0]   st;
        bit [31:0]   st_mask;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    // Reference model state
    bit [31:0] m_bpc = 0, m_st = 0, m_mask = 32'hFFFF_FFFF;
    bit        m_bpc_ok = 1;
    int        m_mode = 0;   // 0 run, 1 break, 2 term

    function automatic bit [31:0] vaddr(int idx);
        return BASE + 32'(4 * idx);
    endfunction

    // rq order: {sbi, rst, ae, rie, trap, fpe, ei}
    task automatic step(string tag, bit [6:0] rq, bit [3:0] tn, bit rt,
                        bit [31:0] pcc, bit [31:0] pcn, bit we, bit sl, bit [31:0] wd);
        exp_t e;
        int   idx;
        bit   acted;
        @(negedge clk);
        {req_sbi, req_rst, req_ae, req_rie, req_trap, req_fpe, req_ei} = rq;
        trap_num = tn; rte = rt; pc_cur = pcc; pc_next = pcn;
        acc_we = we; acc_sel = sl; acc_wdata = wd;
        e.tag = tag; e.redir = 0; e.rpc_ok = 1; e.rpc = 0;
        idx = -1; acted = 0;
        if (m_mode == 0) begin
            if (rq[6]) idx = 1;
            else if (rq[5]) idx = 0;
            else if (rq[4]) idx = 3;
            else if (rq[3]) idx = 2;
            else if (rq[2]) idx = 16 + int'(tn);
            else if (rq[1]) idx = 4;
            else if (rq[0] && m_st[6]) idx = 5;
            if (idx >= 0) begin
                acted = 1; e.redir = 1; e.rpc = vaddr(idx);
                if (idx == 0) begin
                    m_st = 0; m_mask = 32'hFFFF_FFFF;
                end else begin
                    m_bpc = ((idx == 2 || idx == 3) ? pcc : pcn) & ~32'h3;
                    m_bpc_ok = 1;
                    m_st = {m_st[31:16], m_st[7:0], m_st[7:0] & 8'h3F};
                    m_mask = {m_mask[31:16], m_mask[7:0], m_mask[7:0]};
                    if (idx == 1) m_mode = 1;
                end
            end else if (rt) begin
                acted = 1; e.redir = 1; e.rpc = m_bpc; e.rpc_ok = m_bpc_ok;
                m_st[7:0] = m_st[15:8];
                m_mask[7:0] = m_mask[15:8];
                m_mask[15:8] = 8'h00;
                m_bpc_ok = 0;
            end
        end else if (m_mode == 1 && rt) begin
            acted = 1; m_mode = 2;
        end
        if (we && !acted) begin
            if (sl) begin m_st = wd; m_mask = 32'hFFFF_FFFF; end
            else begin m_bpc = wd & ~32'h3; m_bpc_ok = 1; end
        end
        e.term = (m_mode == 2); e.bpc_ok = m_bpc_ok; e.bpc = m_bpc;
        e.st = m_st; e.st_mask = m_mask;
        exp_q.push_back(e);
    endtask

    task automatic idle(string tag);
        step(tag, 7'b0, 4'd0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic chk(string tag, string what, bit ok, bit [31:0] act, bit [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Monitor: comb outputs just after drive, registered outputs one cycle later
    initial begin
        exp_t cur;
        bit   pend = 0;
        forever begin
            @(negedge clk); #1;
            if (pend) begin
                chk(cur.tag, "term_req", term_req == cur.term, 32'(term_req), 32'(cur.term));
                if (cur.bpc_ok) chk(cur.tag, "bpc_q", bpc_q == cur.bpc, bpc_q, cur.bpc);
                chk(cur.tag, "status_q", (status_q & cur.st_mask) == (cur.st & cur.st_mask),
                    status_q & cur.st_mask, cur.st & cur.st_mask);
                pend = 0;
            end
            if (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                chk(cur.tag, "redirect", redirect == cur.redir, 32'(redirect), 32'(cur.redir));
                if (cur.redir && cur.rpc_ok)
                    chk(cur.tag, "redirect_pc", redirect_pc == cur.rpc, redirect_pc, cur.rpc);
                pend = 1;
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset", "redirect", redirect == 0, 32'(redirect), 0);
        chk("R1 reset", "bpc_q", bpc_q == 0, bpc_q, 0);
        chk("R1 reset", "status_q", status_q == 0, status_q, 0);
        chk("R1 reset", "term_req", term_req == 0, 32'(term_req), 0);
        @(negedge clk); rst_n = 1;
        idle("R1 idle");
        step("R11 write status", 7'b0, 0, 0, 0, 0, 1, 1, 32'hA5A5_00C5);
        step("R11 write bpc", 7'b0, 0, 0, 0, 0, 1, 0, 32'h0000_1237);
        step("R5 R6 ext irq", 7'b0000001, 0, 0, 32'h200, 32'h204, 0, 0, 0);
        step("R7 masked irq", 7'b0000001, 0, 0, 32'h300, 32'h304, 0, 0, 0);
        step("R8 return", 7'b0, 0, 1, 0, 0, 0, 0, 0);
        step("R2 trap beats fpe", 7'b0000111, 4'd9, 0, 32'h400, 32'h406, 0, 0, 0);
        step("R2 R4 addr fault", 7'b0011100, 4'd3, 0, 32'h3003, 32'h3008, 0, 0, 0);
        step("R4 reserved instr", 7'b0001000, 0, 0, 32'h5000, 32'h5004, 0, 0, 0);
        step("R3 R5 fpe", 7'b0000010, 0, 0, 32'h6000, 32'h6004, 0, 0, 0);
        step("R3 trap 0", 7'b0000100, 4'd0, 0, 32'h7000, 32'h7004, 0, 0, 0);
        step("R3 trap 15", 7'b0000100, 4'd15, 0, 32'h7100, 32'h7104, 0, 0, 0);
        step("R8 R11 event wins", 7'b0000010, 0, 1, 32'h8000, 32'h8004, 1, 0, 32'hFFF0);
        step("R11 bpc write", 7'b0, 0, 0, 0, 0, 1, 0, 32'h0000_9ABF);
        step("R8 return to bpc", 7'b0, 0, 1, 0, 0, 0, 0, 0);
        step("R10 R2 reset-like", 7'b0110000, 0, 0, 32'hA000, 32'hA004, 0, 0, 0);
        step("R11 enable irq", 7'b0, 0, 0, 0, 0, 1, 1, 32'h0000_0040);
        step("R2 R9 break", 7'b1000001, 0, 0, 32'hB000, 32'hB004, 0, 0, 0);
        step("R9 fault in break", 7'b0011000, 0, 0, 32'hC000, 32'hC004, 0, 0, 0);
        step("R9 break return", 7'b0, 0, 1, 0, 0, 0, 0, 0);
        step("R9 term sticky", 7'b0100010, 0, 1, 32'hD000, 32'hD004, 0, 0, 0);
        step("R11 write in term", 7'b0, 0, 0, 0, 0, 1, 0, 32'h0000_4442);
        idle("R9 idle");
        idle("drain");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule